// File: doc/BRIEF.md
# Limited-Pointer Sharer Entry with Overflow Policies

This block keeps the sharer record for one memory line in a directory that tracks up to 16 nodes. It stores a few node pointers with per-pointer valid flags, an overflow flag, a coarse group vector and an age index. Each cycle it may take one command with a node number. An add command records the node as a sharer. A write command reports every node that must be invalidated, leaving out the writer, and then shrinks the record to the writer alone.

Running out of pointers is handled by a policy picked on a static mode input. Broadcast mode marks the entry overflowed, so that the next write hits every node. No-broadcast mode displaces the oldest pointer and reports the displaced node as an eviction. Coarse mode switches to a vector with one bit per group of two nodes, and a write then invalidates the whole of each marked group. The block only keeps the record and computes the masks. Sending messages and running the home protocol are left to the surrounding logic.

Top module: `dir_lp_entry`

## Requirements
- R1: After reset, `rsp_valid_o` is 0, both masks are 0 and the entry holds no sharer, so the first write returns an empty invalidation mask.
- R2: While free pointers remain, an add (`cmd_op_i`=0) records the node. A write (`cmd_op_i`=1) then returns the recorded sharers as a 16-bit mask in which bit n stands for node n.
- R3: Adding a node that is already recorded changes nothing and evicts nothing.
- R4: When `mode_i` is 0 (broadcast), or 3, which behaves the same way, an add while all pointers are valid sets overflow. A later write then returns all 16 nodes except the writer.
- R5: When `mode_i` is 1 (no-broadcast), an add of a new node while the pointers are full replaces the oldest pointer and reports that node as a one-hot `evict_mask_o`. The slot to replace advances round-robin.
- R6: When `mode_i` is 2 (coarse), an add of a new node while the pointers are full sets overflow and marks group n>>1 for both stored nodes and the new node. A write then returns both nodes of every marked group except the writer.
- R7: In coarse mode, while the entry is overflowed, each further add marks that node's group.
- R8: A write excludes the writer from its mask. It leaves the entry holding only the writer, with overflow and the group vector cleared, so the next write by another node returns only the previous writer.
- R9: `rsp_valid_o` is 1 exactly in the cycle after an accepted command. In any other cycle it is 0 and both masks are 0.
- R10: `evict_mask_o` is zero except for a no-broadcast eviction. `inv_mask_o` is zero in the response to an add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Overflow policy: 0 broadcast, 1 no-broadcast, 2 coarse, 3 as broadcast |
| cmd_valid_i | input | 1 | A command is present this cycle |
| cmd_op_i | input | 1 | 0 add sharer, 1 write |
| cmd_node_i | input | 4 | Node number of the requester |
| rsp_valid_o | output | 1 | Response valid, one cycle after the command |
| inv_mask_o | output | 16 | Nodes to invalidate, bit n is node n |
| evict_mask_o | output | 16 | Sharer displaced by an add |

## Verification
The states that are hard to reach are the overflowed ones and the round-robin position of the age index. Both appear only after a particular run of adds with distinct nodes that follows a write. The bench sweeps every ordered triple of added nodes, plus a fourth derived node and a derived writer, in every mode. This drives the no-broadcast slot through several replacements in a row and produces coarse vectors that mix shared and separate groups. Every record is read back through the write response that starts the next round.

// File: rtl/dir_lp_pkg.sv
package dir_lp_pkg;
  typedef enum logic [1:0] {
    OVF_BCAST  = 2'd0,
    OVF_NOBC   = 2'd1,
    OVF_COARSE = 2'd2,
    OVF_RSVD   = 2'd3
  } ovf_mode_e;

  typedef enum logic {
    OP_ADD   = 1'b0,
    OP_WRITE = 1'b1
  } dir_op_e;
endpackage

// File: rtl/dir_lp_ptr_scan.sv
module dir_lp_ptr_scan #(
  parameter int PTRS  = 2,
  parameter int ID_W  = 4,
  parameter int IDX_W = (PTRS > 1) ? $clog2(PTRS) : 1
) (
  input  logic [PTRS-1:0][ID_W-1:0] ptr_i,
  input  logic [PTRS-1:0]           vld_i,
  input  logic [ID_W-1:0]           node_i,
  output logic                      hit_o,
  output logic                      full_o,
  output logic [IDX_W-1:0]          free_idx_o
);
  logic [PTRS-1:0] hit_vec;

  for (genvar p = 0; p < PTRS; p++) begin : g_cmp
    assign hit_vec[p] = vld_i[p] && (ptr_i[p] == node_i);
  end

  assign hit_o  = |hit_vec;
  assign full_o = &vld_i;

  // lowest free slot wins
  always_comb begin
    free_idx_o = '0;
    for (int p = PTRS - 1; p >= 0; p--) begin
      if (!vld_i[p]) free_idx_o = IDX_W'(p);
    end
  end
endmodule

// File: rtl/dir_lp_expand.sv
module dir_lp_expand #(
  parameter int NODES = 16,
  parameter int PTRS  = 2,
  parameter int GRP   = 2,
  parameter int ID_W  = 4,
  parameter int NGRP  = NODES / GRP
) (
  input  logic [PTRS-1:0][ID_W-1:0] ptr_i,
  input  logic [PTRS-1:0]           vld_i,
  input  logic                      ovf_i,
  input  logic [NGRP-1:0]           cvec_i,
  input  logic [1:0]                mode_i,
  output logic [NODES-1:0]          set_o
);
  import dir_lp_pkg::*;

  logic [NODES-1:0] ptr_set;
  logic [NODES-1:0] coarse_set;

  always_comb begin
    ptr_set = '0;
    for (int p = 0; p < PTRS; p++) begin
      if (vld_i[p]) ptr_set[ptr_i[p]] = 1'b1;
    end
  end

  for (genvar n = 0; n < NODES; n++) begin : g_grp
    assign coarse_set[n] = cvec_i[n / GRP];
  end

  always_comb begin
    if (!ovf_i)                               set_o = ptr_set;
    else if (ovf_mode_e'(mode_i) == OVF_COARSE) set_o = coarse_set;
    else                                      set_o = '1;
  end
endmodule

// File: rtl/dir_lp_entry.sv
module dir_lp_entry #(
  parameter int NODES = 16,
  parameter int PTRS  = 2,
  parameter int GRP   = 2,
  parameter int ID_W  = $clog2(NODES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             cmd_valid_i,
  input  logic             cmd_op_i,
  input  logic [ID_W-1:0]  cmd_node_i,
  output logic             rsp_valid_o,
  output logic [NODES-1:0] inv_mask_o,
  output logic [NODES-1:0] evict_mask_o
);
  import dir_lp_pkg::*;

  localparam int NGRP  = NODES / GRP;
  localparam int GSH   = (GRP > 1) ? $clog2(GRP) : 0;
  localparam int GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam int IDX_W = (PTRS > 1) ? $clog2(PTRS) : 1;

  logic [PTRS-1:0][ID_W-1:0] ptr_q, ptr_d;
  logic [PTRS-1:0]           vld_q, vld_d;
  logic                      ovf_q, ovf_d;
  logic [NGRP-1:0]           cvec_q, cvec_d;
  logic [IDX_W-1:0]          rr_q, rr_d;

  logic                      rsp_valid_q;
  logic [NODES-1:0]          inv_q, inv_d;
  logic [NODES-1:0]          evict_q, evict_d;

  logic                      hit, full;
  logic [IDX_W-1:0]          free_idx;
  logic [NODES-1:0]          cur_set;
  logic [GRP_W-1:0]          new_grp;
  ovf_mode_e                 mode;

  assign mode    = ovf_mode_e'(mode_i);
  assign new_grp = GRP_W'(cmd_node_i >> GSH);

  dir_lp_ptr_scan #(.PTRS(PTRS), .ID_W(ID_W), .IDX_W(IDX_W)) scan_i (
    .ptr_i      (ptr_q),
    .vld_i      (vld_q),
    .node_i     (cmd_node_i),
    .hit_o      (hit),
    .full_o     (full),
    .free_idx_o (free_idx)
  );

  dir_lp_expand #(.NODES(NODES), .PTRS(PTRS), .GRP(GRP), .ID_W(ID_W), .NGRP(NGRP)) exp_i (
    .ptr_i  (ptr_q),
    .vld_i  (vld_q),
    .ovf_i  (ovf_q),
    .cvec_i (cvec_q),
    .mode_i (mode_i),
    .set_o  (cur_set)
  );

  always_comb begin
    ptr_d   = ptr_q;
    vld_d   = vld_q;
    ovf_d   = ovf_q;
    cvec_d  = cvec_q;
    rr_d    = rr_q;
    inv_d   = '0;
    evict_d = '0;
    if (cmd_valid_i) begin
      if (dir_op_e'(cmd_op_i) == OP_WRITE) begin
        inv_d         = cur_set;
        inv_d[cmd_node_i] = 1'b0;
        ptr_d         = '0;
        ptr_d[0]      = cmd_node_i;
        vld_d         = '0;
        vld_d[0]      = 1'b1;
        ovf_d         = 1'b0;
        cvec_d        = '0;
        rr_d          = '0;
      end else if (ovf_q) begin
        if (mode == OVF_COARSE) cvec_d[new_grp] = 1'b1;
      end else if (hit) begin
        // already recorded
      end else if (!full) begin
        ptr_d[free_idx] = cmd_node_i;
        vld_d[free_idx] = 1'b1;
      end else begin
        unique case (mode)
          OVF_NOBC: begin
            evict_d[ptr_q[rr_q]] = 1'b1;
            ptr_d[rr_q]          = cmd_node_i;
            rr_d = (rr_q == IDX_W'(PTRS - 1)) ? '0 : rr_q + 1'b1;
          end
          OVF_COARSE: begin
            ovf_d = 1'b1;
            for (int p = 0; p < PTRS; p++) begin
              cvec_d[GRP_W'(ptr_q[p] >> GSH)] = 1'b1;
            end
            cvec_d[new_grp] = 1'b1;
          end
          default: ovf_d = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q       <= '0;
      vld_q       <= '0;
      ovf_q       <= 1'b0;
      cvec_q      <= '0;
      rr_q        <= '0;
      rsp_valid_q <= 1'b0;
      inv_q       <= '0;
      evict_q     <= '0;
    end else begin
      ptr_q       <= ptr_d;
      vld_q       <= vld_d;
      ovf_q       <= ovf_d;
      cvec_q      <= cvec_d;
      rr_q        <= rr_d;
      rsp_valid_q <= cmd_valid_i;
      inv_q       <= inv_d;
      evict_q     <= evict_d;
    end
  end

  assign rsp_valid_o  = rsp_valid_q;
  assign inv_mask_o   = inv_q;
  assign evict_mask_o = evict_q;
endmodule

// File: rtl/dir_lp_entry_chk.sv
module dir_lp_entry_chk #(
  parameter int NODES = 16,
  parameter int ID_W  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             cmd_valid_i,
  input logic             cmd_op_i,
  input logic [ID_W-1:0]  cmd_node_i,
  input logic             rsp_valid_o,
  input logic [NODES-1:0] inv_mask_o,
  input logic [NODES-1:0] evict_mask_o,
  input logic             ovf_q
);
  assert_rsp_after_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> rsp_valid_o);

  assert_no_rsp_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !rsp_valid_o);

  assert_quiet_masks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (inv_mask_o == '0 && evict_mask_o == '0));

  assert_add_no_inv_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !cmd_op_i) |=> inv_mask_o == '0);

  assert_write_no_evict_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i) |=> evict_mask_o == '0);

  assert_writer_excluded_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i) |=> inv_mask_o[$past(cmd_node_i)] == 1'b0);

  assert_evict_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(evict_mask_o));

  assert_evict_only_nobc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && mode_i != 2'd1) |=> evict_mask_o == '0);

  assert_bcast_all_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i && ovf_q && (mode_i == 2'd0 || mode_i == 2'd3))
    |=> $countones(inv_mask_o) == NODES - 1);
endmodule

bind dir_lp_entry dir_lp_entry_chk #(.NODES(NODES), .ID_W(ID_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_op_i     (cmd_op_i),
  .cmd_node_i   (cmd_node_i),
  .rsp_valid_o  (rsp_valid_o),
  .inv_mask_o   (inv_mask_o),
  .evict_mask_o (evict_mask_o),
  .ovf_q        (ovf_q)
);

// File: tb/dir_lp_entry_tb_top.sv
`timescale 1ns/1ps
module dir_lp_entry_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic        cmd_valid;
  logic        cmd_op;
  logic [3:0]  cmd_node;
  logic        rsp_valid;
  logic [15:0] inv_mask;
  logic [15:0] evict_mask;

  int n_chk = 0;
  int n_err = 0;

  // model of the record, derived from the requirements
  logic [3:0]  m_p [2];
  logic        m_v [2];
  logic        m_ovf;
  logic [7:0]  m_cv;
  int          m_rr;

  always #2 clk = ~clk;

  dir_lp_entry dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .mode_i       (mode),
    .cmd_valid_i  (cmd_valid),
    .cmd_op_i     (cmd_op),
    .cmd_node_i   (cmd_node),
    .rsp_valid_o  (rsp_valid),
    .inv_mask_o   (inv_mask),
    .evict_mask_o (evict_mask)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_p[0] = '0; m_p[1] = '0; m_v[0] = 1'b0; m_v[1] = 1'b0;
    m_ovf = 1'b0; m_cv = '0; m_rr = 0;
  endtask

  function automatic logic [15:0] model_set();
    logic [15:0] s = '0;
    if (!m_ovf) begin
      for (int p = 0; p < 2; p++) if (m_v[p]) s[m_p[p]] = 1'b1;
    end else if (mode == 2'd2) begin
      for (int n = 0; n < 16; n++) s[n] = m_cv[n / 2];
    end else s = 16'hFFFF;
    return s;
  endfunction

  task automatic do_reset();
    cmd_valid = 1'b0; cmd_op = 1'b0; cmd_node = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 valid after reset", 32'(rsp_valid), 0);
    check(inv_mask == '0 && evict_mask == '0, "R1 masks after reset", {inv_mask, evict_mask}, 0);
  endtask

  task automatic do_cmd(input bit op, input int node);
    logic [15:0] e_inv = '0;
    logic [15:0] e_ev  = '0;
    string tag;
    logic [3:0] nd = 4'(node);
    if (op) begin
      tag = m_ovf ? ((mode == 2'd2) ? "R6 write coarse" : "R4 write broadcast") : "R2/R8 write";
      e_inv = model_set();
      e_inv[nd] = 1'b0;
      model_clear();
      m_p[0] = nd; m_v[0] = 1'b1;
    end else if (m_ovf) begin
      tag = (mode == 2'd2) ? "R7 add overflowed" : "R4 add overflowed";
      if (mode == 2'd2) m_cv[nd / 2] = 1'b1;
    end else if ((m_v[0] && m_p[0] == nd) || (m_v[1] && m_p[1] == nd)) begin
      tag = "R3 duplicate add";
    end else if (!m_v[0]) begin
      tag = "R2 add"; m_p[0] = nd; m_v[0] = 1'b1;
    end else if (!m_v[1]) begin
      tag = "R2 add"; m_p[1] = nd; m_v[1] = 1'b1;
    end else if (mode == 2'd1) begin
      tag = "R5 evict oldest";
      e_ev[m_p[m_rr]] = 1'b1;
      m_p[m_rr] = nd;
      m_rr = 1 - m_rr;
    end else if (mode == 2'd2) begin
      tag = "R6 coarse overflow";
      m_ovf = 1'b1;
      m_cv[m_p[0] / 2] = 1'b1; m_cv[m_p[1] / 2] = 1'b1; m_cv[nd / 2] = 1'b1;
    end else begin
      tag = "R4 set overflow";
      m_ovf = 1'b1;
    end
    cmd_valid = 1'b1; cmd_op = op; cmd_node = nd;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(rsp_valid == 1'b1, {tag, " R9 valid"}, 32'(rsp_valid), 1);
    check(inv_mask == e_inv, {tag, " R10 inv"}, 32'(inv_mask), 32'(e_inv));
    check(evict_mask == e_ev, {tag, " R10 evict"}, 32'(evict_mask), 32'(e_ev));
  endtask

  task automatic do_idle();
    @(negedge clk);
    check(rsp_valid == 1'b0 && inv_mask == '0 && evict_mask == '0, "R9 idle",
          {15'd0, rsp_valid, inv_mask}, 0);
  endtask

  initial begin
    rst_n = 1'b0; mode = 2'd0;
    cmd_valid = 1'b0; cmd_op = 1'b0; cmd_node = '0;
    model_clear();
    for (int md = 0; md < 4; md++) begin
      mode = 2'(md);
      do_reset();
      do_cmd(1'b1, 5);  // R1: empty record returns nothing
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          for (int c = 0; c < 16; c++) begin
            do_cmd(1'b1, (a * 3 + c + md) % 16);
            do_cmd(1'b0, a);
            do_cmd(1'b0, b);
            do_cmd(1'b0, c);
            do_cmd(1'b0, (c + 7) % 16);
            if (c == 15) do_idle();
          end
        end
      end
      do_cmd(1'b1, 0);
      do_cmd(1'b1, 9);  // R8: only the previous writer remains
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule